// File: doc/BRIEF.md
# Staggered Clock-Gate Enable Sequencer

This block drives the enable pins of the clock-gate cells for a three-stage datapath. The datapath's clocks are split into eight gating domains. Three cover dynamic logic: the upper, middle and lower thirds of the first stage. Five cover static logic. Three of those pair with the dynamic thirds of stage one, and the other two cover stages two and three. A single configuration word holds one bit per domain and sets which domains should run. Each bit is independent of the others.

Enables are removed at once, but they are granted one domain per clock. When several domains are requested together, the lowest-indexed outstanding domain is released first. This spreads the current step on the supply and the clock network over several cycles instead of one. The enables leave the block from registers clocked on the falling edge, so they only move while the clock is low and cannot chop a high phase of a gated clock. A busy flag shows that a staggered turn-on has not yet finished. A registered readback port returns either the configuration word or the current enable state.

Top module: `cg_domain_sequencer`

## Requirements
- R1: After synchronous reset, all enables, `busy` and `rd_data` are 0 and the configuration word is 0.
- R2: An enable is never 1 for a domain whose configuration bit is 0. Once the sequence has settled, the enables equal the configuration. Configuration bits 0..2 map to `dyn_en[0..2]` and bits 3..7 map to `sta_en[0..4]`.
- R3: At each rising edge, at most one domain moves from disabled to enabled.
- R4: Clearing a configuration bit with a write removes that domain's enable at the falling edge that follows the write's rising edge.
- R5: Outstanding domains are released lowest configuration-bit index first. The first release happens at the write's own rising edge, and each further release happens one rising edge later.
- R6: `busy` updates at each rising edge. It is 1 exactly when some configured domain is not yet enabled.
- R7: Enables change only on falling clock edges. They are stable for the whole high phase of the clock.
- R8: `rd_data` is registered at each rising edge. With `rd_sel`=0 it holds the configuration word. With `rd_sel`=1 it holds the enable state, bit order as in R2. Both values are as updated by that edge.
- R9: `cfg_wdata` has no effect while `cfg_wr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 8 | New configuration word, one bit per domain |
| rd_sel | input | 1 | Readback view: 0 selects the configuration, 1 selects the enables |
| rd_data | output | 8 | Registered readback value |
| busy | output | 1 | Staggered turn-on still in progress |
| dyn_en | output | 3 | Enables for the dynamic-logic domains |
| sta_en | output | 5 | Enables for the static-logic domains |

## Verification
A write at a rising edge updates `busy` and `rd_data` at that same edge. Turn-offs and the first turn-on reach the enable pins at the falling edge half a cycle later, and each further turn-on comes one rising edge after the one before. The bench drives inputs and takes its main samples 2 ns before each rising edge, when both edges of the previous cycle have passed. It samples again 2 ns after the rising edge to confirm that the enables still hold the prior cycle's value. An arithmetic model then advances by exactly one cycle per edge. The model is swept over every configuration word written from the all-off state, over one transition out of each word, and over a stream of back-to-back writes that interrupt sequences still in progress.

// File: rtl/cg_seq_pkg.sv
`timescale 1ns/1ps
package cg_seq_pkg;
  localparam int DEF_DYN_DOMS = 3;
  localparam int DEF_STA_DOMS = 5;

  typedef enum logic {
    VIEW_CFG = 1'b0,
    VIEW_EN  = 1'b1
  } rd_view_e;
endpackage

// File: rtl/cg_cfg_reg.sv
`timescale 1ns/1ps
module cg_cfg_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cfg_nxt,
  output logic [W-1:0] cfg_q
);
  // Value that the rising edge is about to store; the arbiter uses it so a
  // write acts at its own edge.
  always_comb cfg_nxt = wr ? wdata : cfg_q;

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= '0;
    else     cfg_q <= cfg_nxt;
  end

  // R9: with no strobe the stored word holds
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !wr |=> (cfg_q == $past(cfg_q)));
endmodule

// File: rtl/cg_release_arb.sv
`timescale 1ns/1ps
module cg_release_arb #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cfg_nxt,
  input  logic [W-1:0] cfg_q,
  output logic [W-1:0] grant_nxt,
  output logic [W-1:0] grant_q,
  output logic         busy_q
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] pending;
  logic [W-1:0] pick;

  always_comb begin
    pending   = cfg_nxt & ~grant_q;
    pick      = pending & (~pending + ONE);   // isolate lowest outstanding domain
    grant_nxt = (grant_q & cfg_nxt) | pick;   // drops act at once, one add per edge
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q <= '0;
      busy_q  <= 1'b0;
    end else begin
      grant_q <= grant_nxt;
      busy_q  <= |(cfg_nxt & ~grant_nxt);
    end
  end

  // R2: no grant without a configuration bit
  assert_subset_R2: assert property (@(posedge clk) disable iff (rst)
    (grant_q & ~cfg_q) == '0);
  // R3: at most one new grant per rising edge
  assert_one_release_R3: assert property (@(posedge clk) disable iff (rst)
    $countones(grant_q & ~$past(grant_q)) <= 1);
  // R4: a cleared bit loses its grant at the write edge
  assert_off_now_R4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((grant_q & ~$past(cfg_nxt)) == '0));
  // R5: nothing below a new grant is left outstanding
  assert_lowest_first_R5: assert property (@(posedge clk) disable iff (rst)
    (cfg_q & ~grant_q & ((grant_q & ~$past(grant_q)) - ONE)) == '0);
  // R6: busy exactly while the grants lag the configuration
  assert_busy_clear_R6: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> (grant_q == cfg_q));
  assert_busy_set_R6: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (grant_q != cfg_q));
endmodule

// File: rtl/cg_fall_stage.sv
`timescale 1ns/1ps
module cg_fall_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(negedge clk) begin
      if (rst) q[i] <= 1'b0;
      else     q[i] <= d[i];
    end
  end

  // R7: during the high phase the pins hold what the low phase captured
  assert_en_tracks_R7: assert property (@(posedge clk) disable iff (rst)
    q == d);
endmodule

// File: rtl/cg_domain_sequencer.sv
`timescale 1ns/1ps
module cg_domain_sequencer
  import cg_seq_pkg::*;
#(
  parameter int DYN_DOMS = DEF_DYN_DOMS,
  parameter int STA_DOMS = DEF_STA_DOMS
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cfg_wr,
  input  logic [DYN_DOMS+STA_DOMS-1:0] cfg_wdata,
  input  logic                         rd_sel,
  output logic [DYN_DOMS+STA_DOMS-1:0] rd_data,
  output logic                         busy,
  output logic [DYN_DOMS-1:0]          dyn_en,
  output logic [STA_DOMS-1:0]          sta_en
);
  localparam int DOMS = DYN_DOMS + STA_DOMS;

  logic [DOMS-1:0] cfg_nxt, cfg_q, grant_nxt, grant_q, en_q;

  cg_cfg_reg #(.W(DOMS)) u_cfg (
    .clk(clk), .rst(rst), .wr(cfg_wr), .wdata(cfg_wdata),
    .cfg_nxt(cfg_nxt), .cfg_q(cfg_q)
  );

  cg_release_arb #(.W(DOMS)) u_arb (
    .clk(clk), .rst(rst), .cfg_nxt(cfg_nxt), .cfg_q(cfg_q),
    .grant_nxt(grant_nxt), .grant_q(grant_q), .busy_q(busy)
  );

  cg_fall_stage #(.W(DOMS)) u_fall (
    .clk(clk), .rst(rst), .d(grant_q), .q(en_q)
  );

  always_ff @(posedge clk) begin
    if (rst)                  rd_data <= '0;
    else if (rd_sel == VIEW_EN) rd_data <= grant_nxt;
    else                      rd_data <= cfg_nxt;
  end

  assign dyn_en = en_q[DYN_DOMS-1:0];
  assign sta_en = en_q[DOMS-1:DYN_DOMS];

  // R8: readback of the configuration view follows the stored word
  assert_readback_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_sel == VIEW_CFG) |=> (rd_data == cfg_q));
endmodule

// File: tb/tb_cg_domain_sequencer.sv
`timescale 1ns/1ps
module tb_cg_domain_sequencer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic       rd_sel = 1'b0;
  logic [7:0] rd_data;
  logic       busy;
  logic [2:0] dyn_en;
  logic [4:0] sta_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] m_cfg = '0, m_en = '0;
  logic [7:0] lfsr = 8'h5B;

  always #4 clk = ~clk;

  cg_domain_sequencer dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .rd_sel(rd_sel), .rd_data(rd_data), .busy(busy),
    .dyn_en(dyn_en), .sta_en(sta_en)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic next_lfsr();
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
  endtask

  // Called 2 ns before a rising edge; returns 2 ns before the following one.
  task automatic cycle(input logic wr, input logic [7:0] d, input logic sel);
    logic [7:0] cfg_n, en_n, old_en, pins;
    bit found;
    cfg_wr = wr; cfg_wdata = d; rd_sel = sel;
    old_en = m_en;
    cfg_n = wr ? d : m_cfg;
    en_n = m_en & cfg_n;
    found = 0;
    for (int i = 0; i < 8; i++)
      if (!found && cfg_n[i] && !m_en[i]) begin en_n[i] = 1'b1; found = 1; end
    @(posedge clk);
    #2;
    chk("R7 stable in high phase", {sta_en, dyn_en}, old_en);
    #4;
    m_cfg = cfg_n; m_en = en_n;
    pins = {sta_en, dyn_en};
    chk("R5 enable sequence", pins, m_en);
    chk("R2 never beyond config", pins & ~m_cfg, 8'h00);
    chk("R3 one turn-on per edge", ($countones(pins & ~old_en) <= 1) ? 8'h1 : 8'h0, 8'h1);
    chk("R4 turn-off at once", pins & old_en & ~cfg_n, 8'h00);
    chk("R6 busy", {7'b0, busy}, {7'b0, |(m_cfg & ~m_en)});
    chk("R8 readback", rd_data, sel ? m_en : m_cfg);
    cfg_wr = 1'b0;
  endtask

  task automatic settle(input int n);
    for (int k = 0; k < n; k++) begin
      next_lfsr();
      cycle(1'b0, lfsr, k[0]);   // random data with no strobe (R9)
    end
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #6;
    rst = 1'b0;
    // R1: reset state
    chk("R1 enables", {sta_en, dyn_en}, 8'h00);
    chk("R1 busy", {7'b0, busy}, 8'h00);
    chk("R1 rd_data", rd_data, 8'h00);
    cycle(1'b0, 8'hFF, 1'b0);
    chk("R1 config stays 0", rd_data, 8'h00);

    // R2/R5: every word from the all-off state, then one transition out of it
    for (int c = 0; c < 256; c++) begin
      cycle(1'b1, 8'h00, 1'b1);
      cycle(1'b1, c[7:0], c[0]);
      settle(9);
      chk("R2 settled equals config", {sta_en, dyn_en}, c[7:0]);
      cycle(1'b1, c[7:0] * 8'd37 + 8'd11, c[1]);
      settle(9);
      chk("R2 settled after transition", {sta_en, dyn_en}, m_cfg);
    end

    // R9: strobe low, data ignored
    cycle(1'b1, 8'hA5, 1'b0);
    settle(9);
    for (int k = 0; k < 4; k++) begin
      cycle(1'b0, 8'h5A ^ k[7:0], 1'b0);
      chk("R9 config held", rd_data, 8'hA5);
      chk("R9 enables held", {sta_en, dyn_en}, 8'hA5);
    end

    // R5 explicit: all on from off, dynamic first then static, one per edge
    cycle(1'b1, 8'h00, 1'b1);
    cycle(1'b1, 8'hFF, 1'b1);
    chk("R5 first release dyn0", {sta_en, dyn_en}, 8'h01);
    cycle(1'b0, 8'h00, 1'b1);
    chk("R5 second release dyn1", {sta_en, dyn_en}, 8'h03);
    settle(8);
    chk("R6 busy clear when done", {7'b0, busy}, 8'h00);

    // back-to-back writes interrupting sequences
    for (int k = 0; k < 400; k++) begin
      next_lfsr();
      cycle(lfsr[0] | lfsr[3], lfsr ^ 8'h3C, lfsr[6]);
    end
    settle(10);
    chk("R2 final equals config", {sta_en, dyn_en}, m_cfg);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1600000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule